// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error and Data-Ready Flags

This block turns an idle-high asynchronous serial line into parallel characters. It runs from a clock at sixteen times the bit rate. A falling edge on the line starts a character. The start is confirmed at mid-bit. Each later bit is taken at the centre of its bit cell. Characters carry 5 to 8 data bits, sent least significant bit first, and may carry a parity bit.

When the stop bit has been sampled, the assembled character moves into a holding register. Four flags update at that moment:
- a parity mismatch flag,
- a missing stop bit flag,
- an overrun flag,
- a data-ready flag.

The host clears the data-ready flag with a low-active strobe. Word length, parity enable and parity sense come from a control word, which is latched while a load input is high.

Disconnecting the data bus and the flag outputs is modelled as two output enables, which the host-side bus logic uses.

Top module: `rxu_top`

## Requirements
- R1: A falling edge on the line is confirmed only if the line is still low 8 clocks later. A low pulse shorter than that receives no character and leaves `dataAvail` and `rxData` unchanged.
- R2: The word select encodes the data bit count: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. Holding-register bits above the word length read 0.
- R3: With parity enabled, `parityErr` goes to 1 on transfer when the count of ones in the data and parity bit is odd under even sense (`cfgEvenPar`=1), or even under odd sense (`cfgEvenPar`=0). Otherwise it goes to 0.
- R4: With the parity-off bit latched, no parity bit is expected: the stop bit follows the last data bit. `parityErr` reads 0 at once, even if it was high before.
- R5: `frameErr` goes to 1 on transfer when the bit sampled after the data bits (and after the parity bit, if enabled) is low. It goes to 0 when that bit is high.
- R6: `overrunErr` takes, on each transfer, the value `dataAvail` had just before that transfer.
- R7: `dataAvail` goes to 1 on each transfer. It goes to 0 in the cycle after `daClearN` is sampled low, unless a transfer happens in that same cycle.
- R8: `frameErr`, `overrunErr` and the latched parity result change only on a transfer. Clearing `dataAvail` leaves them unchanged.
- R9: A high on `rst` clears the holding register, all flags and the control word. The cleared control word means 5 data bits, parity on, odd sense.
- R10: `dataDrive` is the inverse of `dataDisc`, and `statusDrive` is the inverse of `statDisc`.
- R11: The control word is taken from the configuration inputs only while `ctrlLoad` is high. Changes to those inputs while `ctrlLoad` is low do not affect reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16x the bit rate |
| rst | input | 1 | Master reset, active high |
| serialIn | input | 1 | Serial line, idle high |
| ctrlLoad | input | 1 | Latches the control word while high |
| cfgParityOff | input | 1 | Control: 1 disables parity |
| cfgEvenPar | input | 1 | Control: 1 even parity, 0 odd |
| cfgWordSel | input | 2 | Control: word length select |
| daClearN | input | 1 | Low clears the data-ready flag |
| dataDisc | input | 1 | High disconnects the data bus |
| statDisc | input | 1 | High disconnects the flags |
| rxData | output | 8 | Holding register contents |
| dataDrive | output | 1 | Enable for the data bus drivers |
| parityErr | output | 1 | Parity mismatch flag |
| frameErr | output | 1 | Missing stop bit flag |
| overrunErr | output | 1 | Character landed while data-ready was set |
| dataAvail | output | 1 | Character ready in holding register |
| statusDrive | output | 1 | Enable for the flag drivers |

## Verification
The hardest state to reach from the ports is the rejected start. The line must fall and come back high before the mid-bit check, then the bench must show that nothing was received. The stimulus holds the line low for six clocks, waits several bit times, and confirms that the data-ready flag and the holding register have not changed. It then sends a proper character to show the receiver recovered to idle. Overrun is reached by sending two characters back to back without a clear. A reset in the middle of a frame is followed by a character sent with the reset-default control word.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  // control word as latched from the configuration inputs
  typedef struct packed {
    logic       parityOff;
    logic       evenPar;
    logic [1:0] wordSel;
  } rxCfg_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startFrame;
    logic takeData;
    logic takeParity;
    logic transfer;
  } rxStrobe_t;

endpackage

// File: rtl/rxu_ctrl.sv
module rxu_ctrl
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lineIn,
  input  logic [1:0]                  wordSel,
  input  logic                        parityOn,
  output rxStrobe_t                   stb,
  output logic [$clog2(DATA_MAX)-1:0] bitIdx
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP} rxState_t;

  rxState_t          state;
  logic [CNT_W-1:0]  cnt;
  logic              lineDly;
  logic [IDX_W-1:0]  lastIdx;
  logic              cellEnd;

  assign lastIdx = IDX_W'(4) + IDX_W'(wordSel);
  assign cellEnd = (cnt == FULL_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      lineDly <= 1'b1;
    end else begin
      lineDly <= lineIn;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (lineDly && !lineIn) state <= S_START;
        end
        S_START: begin
          if (cnt == HALF_END) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= lineIn ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (cellEnd) begin
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == lastIdx) state <= parityOn ? S_PARITY : S_STOP;
          end
        end
        S_PARITY: begin
          cnt <= cnt + 1'b1;
          if (cellEnd) state <= S_STOP;
        end
        S_STOP: begin
          cnt <= cnt + 1'b1;
          if (cellEnd) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.startFrame = (state == S_START) && (cnt == HALF_END) && !lineIn;
    stb.takeData   = (state == S_DATA) && cellEnd;
    stb.takeParity = (state == S_PARITY) && cellEnd;
    stb.transfer   = (state == S_STOP) && cellEnd;
  end
endmodule

// File: rtl/rxu_datapath.sv
module rxu_datapath
  import rxu_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lineIn,
  input  rxStrobe_t                   stb,
  input  logic [$clog2(DATA_MAX)-1:0] bitIdx,
  input  logic                        ctrlLoad,
  input  rxCfg_t                      cfgIn,
  input  logic                        daClearN,
  output rxCfg_t                      cfg,
  output logic [DATA_MAX-1:0]         holdData,
  output logic                        parityErr,
  output logic                        frameErr,
  output logic                        overrunErr,
  output logic                        dataAvail
);
  logic [DATA_MAX-1:0] shiftReg;
  logic                runXor;
  logic                parBit;
  logic                peReg;

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (ctrlLoad) cfg <= cfgIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      runXor   <= 1'b0;
      parBit   <= 1'b0;
    end else if (stb.startFrame) begin
      shiftReg <= '0;
      runXor   <= 1'b0;
    end else if (stb.takeData) begin
      shiftReg[bitIdx] <= lineIn;
      runXor           <= runXor ^ lineIn;
    end else if (stb.takeParity) begin
      parBit <= lineIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData   <= '0;
      peReg      <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      dataAvail  <= 1'b0;
    end else if (stb.transfer) begin
      holdData   <= shiftReg;
      peReg      <= ~cfg.parityOff & (runXor ^ parBit ^ ~cfg.evenPar);
      frameErr   <= ~lineIn;
      overrunErr <= dataAvail;
      dataAvail  <= 1'b1;
    end else if (!daClearN) begin
      dataAvail <= 1'b0;
    end
  end

  assign parityErr = peReg & ~cfg.parityOff;
endmodule

// File: rtl/rxu_top.sv
module rxu_top
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_MAX    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serialIn,
  input  logic                ctrlLoad,
  input  logic                cfgParityOff,
  input  logic                cfgEvenPar,
  input  logic [1:0]          cfgWordSel,
  input  logic                daClearN,
  input  logic                dataDisc,
  input  logic                statDisc,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataDrive,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr,
  output logic                dataAvail,
  output logic                statusDrive
);
  localparam int IDX_W = $clog2(DATA_MAX);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineIn;
  rxStrobe_t              stb;
  rxCfg_t                 cfg;
  rxCfg_t                 cfgIn;
  logic [IDX_W-1:0]       bitIdx;

  always_ff @(posedge clk) begin
    if (rst) syncReg <= '1;
    else     syncReg <= {syncReg[SYNC_STAGES-2:0], serialIn};
  end
  assign lineIn = syncReg[SYNC_STAGES-1];

  assign cfgIn = '{parityOff: cfgParityOff, evenPar: cfgEvenPar, wordSel: cfgWordSel};

  rxu_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .lineIn(lineIn), .wordSel(cfg.wordSel),
    .parityOn(~cfg.parityOff), .stb(stb), .bitIdx(bitIdx)
  );

  rxu_datapath #(.DATA_MAX(DATA_MAX)) u_dp (
    .clk(clk), .rst(rst), .lineIn(lineIn), .stb(stb), .bitIdx(bitIdx),
    .ctrlLoad(ctrlLoad), .cfgIn(cfgIn), .daClearN(daClearN), .cfg(cfg),
    .holdData(rxData), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .dataAvail(dataAvail)
  );

  assign dataDrive   = ~dataDisc;
  assign statusDrive = ~statDisc;
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker
  import rxu_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input rxStrobe_t stb,
  input rxCfg_t    cfg,
  input logic      daClearN,
  input logic      dataAvail,
  input logic      parityErr,
  input logic      frameErr,
  input logic      overrunErr,
  input logic [7:0] rxData
);
  function automatic logic [7:0] upperMask(input logic [1:0] sel);
    return ~((8'd1 << (5 + sel)) - 8'd1);
  endfunction

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!dataAvail && !frameErr && !overrunErr && rxData == '0));

  // R7
  da_set_chk: assert property (@(posedge clk) disable iff (rst)
    stb.transfer |=> dataAvail);

  // R7
  da_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.transfer && !daClearN) |=> !dataAvail);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    stb.transfer |=> (overrunErr == $past(dataAvail)));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.transfer |=> $stable({frameErr, overrunErr}));

  // R4
  parity_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.parityOff |-> !parityErr);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stb.transfer |=> ((rxData & upperMask($past(cfg.wordSel))) == '0));

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.startFrame, stb.takeData, stb.takeParity, stb.transfer}));
endmodule

bind rxu_top rxu_checker u_chk (
  .clk(clk), .rst(rst), .stb(stb), .cfg(cfg), .daClearN(daClearN),
  .dataAvail(dataAvail), .parityErr(parityErr), .frameErr(frameErr),
  .overrunErr(overrunErr), .rxData(rxData)
);

// File: tb/rxu_top_tb.sv
module rxu_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b1;
  logic       ctrlLoad = 1'b0;
  logic       cfgParityOff = 1'b0;
  logic       cfgEvenPar = 1'b0;
  logic [1:0] cfgWordSel = 2'b00;
  logic       daClearN = 1'b1;
  logic       dataDisc = 1'b0;
  logic       statDisc = 1'b0;
  logic [7:0] rxData;
  logic       dataDrive, parityErr, frameErr, overrunErr, dataAvail, statusDrive;

  int totalCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  rxu_top u_dut (
    .clk(clk), .rst(rst), .serialIn(serialIn), .ctrlLoad(ctrlLoad),
    .cfgParityOff(cfgParityOff), .cfgEvenPar(cfgEvenPar), .cfgWordSel(cfgWordSel),
    .daClearN(daClearN), .dataDisc(dataDisc), .statDisc(statDisc),
    .rxData(rxData), .dataDrive(dataDrive), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr), .dataAvail(dataAvail),
    .statusDrive(statusDrive)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadCfg(input logic po, input logic ev, input logic [1:0] ws);
    cfgParityOff = po; cfgEvenPar = ev; cfgWordSel = ws;
    ctrlLoad = 1'b1; tick(1); ctrlLoad = 1'b0; tick(1);
  endtask

  task automatic clearDa();
    daClearN = 1'b0; tick(1); daClearN = 1'b1; tick(1);
  endtask

  task automatic putBit(input logic b);
    serialIn = b; tick(16);
  endtask

  // len data bits, optional parity (flipped on request), chosen stop level
  task automatic sendFrame(input logic [7:0] d, input int len, input logic parOn,
                           input logic ev, input logic flip, input logic stopVal);
    logic p;
    p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    if (!ev) p = ~p;
    putBit(1'b0);
    for (int i = 0; i < len; i++) putBit(d[i]);
    if (parOn) putBit(p ^ flip);
    putBit(stopVal);
    serialIn = 1'b1; tick(8);
  endtask

  function automatic logic [7:0] maskOf(input int len);
    return 8'((9'd1 << len) - 9'd1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [7:0] vals [6];
    logic [7:0] hold;
    vals = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};
    tick(3);
    // R9 reset state
    check("R9 data", rxData, 8'h00);
    check("R9 flags", {4'b0, parityErr, frameErr, overrunErr, dataAvail}, 8'h00);
    rst = 1'b0; tick(4);

    // R10 disconnect enables
    for (int k = 0; k < 4; k++) begin
      dataDisc = k[0]; statDisc = k[1]; tick(1);
      check("R10 enables", {6'b0, dataDrive, statusDrive}, {6'b0, ~k[0], ~k[1]});
    end
    dataDisc = 1'b0; statDisc = 1'b0;

    // R9 reset control word: 5 bits, parity on, odd
    sendFrame(8'h15, 5, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 default cfg data", rxData, 8'h15);
    check("R9 default cfg parity", {7'b0, parityErr}, 8'h00);
    clearDa();

    // R2 R3 R4 sweep: word length x parity mode x data
    for (int ws = 0; ws < 4; ws++) begin
      for (int pm = 0; pm < 3; pm++) begin
        loadCfg(pm == 0, pm == 1, 2'(ws));
        for (int v = 0; v < 6; v++) begin
          clearDa();
          sendFrame(vals[v], 5 + ws, pm != 0, pm == 1, 1'b0, 1'b1);
          check("R2 data", rxData, vals[v] & maskOf(5 + ws));
          check("R3 parity ok", {7'b0, parityErr}, 8'h00);
          check("R5 stop ok", {7'b0, frameErr}, 8'h00);
          check("R7 set", {7'b0, dataAvail}, 8'h01);
          check("R6 no overrun", {7'b0, overrunErr}, 8'h00);
        end
      end
    end

    // R3 parity mismatch, both senses
    for (int ev = 0; ev < 2; ev++) begin
      loadCfg(1'b0, ev[0], 2'b11);
      clearDa();
      sendFrame(8'h6B, 8, 1'b1, ev[0], 1'b1, 1'b1);
      check("R3 mismatch", {7'b0, parityErr}, 8'h01);
    end
    // R8 clear leaves flags
    clearDa();
    check("R8 parity held", {7'b0, parityErr}, 8'h01);
    check("R7 cleared", {7'b0, dataAvail}, 8'h00);
    // R4 clamp on parity-off load
    loadCfg(1'b1, 1'b0, 2'b11);
    check("R4 clamp", {7'b0, parityErr}, 8'h00);

    // R5 missing stop bit
    sendFrame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 frame error", {7'b0, frameErr}, 8'h01);
    clearDa();
    check("R8 frame held", {7'b0, frameErr}, 8'h01);
    sendFrame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 frame clear", {7'b0, frameErr}, 8'h00);

    // R6 overrun
    clearDa();
    sendFrame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 overrun set", {7'b0, overrunErr}, 8'h01);
    check("R6 newest data", rxData, 8'h22);
    clearDa();
    check("R8 overrun held", {7'b0, overrunErr}, 8'h01);
    sendFrame(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 overrun clear", {7'b0, overrunErr}, 8'h00);

    // R11 inputs ignored without load
    cfgParityOff = 1'b0; cfgEvenPar = 1'b1; cfgWordSel = 2'b00;
    clearDa();
    sendFrame(8'hE7, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 held cfg", rxData, 8'hE7);
    check("R11 no parity", {7'b0, parityErr}, 8'h00);

    // R1 false start
    clearDa();
    hold = rxData;
    serialIn = 1'b0; tick(6); serialIn = 1'b1; tick(64);
    check("R1 no char", {7'b0, dataAvail}, 8'h00);
    check("R1 data kept", rxData, hold);
    sendFrame(8'h4D, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 recovery", rxData, 8'h4D);

    // R9 reset mid-frame
    serialIn = 1'b0; tick(40);
    rst = 1'b1; tick(2);
    check("R9 mid reset data", rxData, 8'h00);
    check("R9 mid reset flags", {4'b0, parityErr, frameErr, overrunErr, dataAvail}, 8'h00);
    serialIn = 1'b1; tick(2); rst = 1'b0; tick(4);
    sendFrame(8'h0A, 5, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9 cfg cleared", rxData, 8'h0A);
    check("R9 cfg parity", {7'b0, parityErr}, 8'h00);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule